// File: doc/BRIEF.md
# ULPI Register Access Viewport

This block sits between a memory-mapped control port and the 8-bit link side of a ULPI PHY bus. Software sees one 32-bit word. It writes a command into that word that carries a start flag, a direction bit, a register address and a data byte. The block then runs the matching ULPI immediate register write or read on the PHY bus. It clears the start flag once the transaction is finished. For a read, the byte that the PHY returns is placed in a separate byte of the same word, so a single poll gives both completion and data.

The PHY can take the bus at any time by raising `ulpi_dir`. If that happens before the command has been accepted, the transaction stops and the block sends it again from the command byte once the PHY releases the bus. A watchdog limits how long a transaction may wait for the PHY. When the limit is reached, the start flag is cleared and a sticky timeout flag is set. Software therefore never polls a flag that will not clear.

Top module: `ulpi_regport`

## Requirements
- R1: After reset the viewport word reads 0, `ulpi_data_oe` is 0 and `ulpi_stp` is 0.
- R2: The word has this layout: bit 31 is the sticky timeout flag, bit 30 is run, bit 29 is direction (1 = write, 0 = read), bits 23:16 are the register address, bits 15:8 are the read-back byte, bits 7:0 are the write data, and bits 28:24 read as 0. An idle write with bit 30 set starts a transaction. Bit 30 reads 1 until the transaction ends and reads 0 from the cycle after its last bus cycle.
- R3: A write transaction drives the byte `{2'b10, addr[5:0]}` and holds it until `ulpi_nxt` is sampled high. It then drives the data byte and holds it until `ulpi_nxt` is sampled high. After that it drives `ulpi_stp` high for exactly one cycle, with the data bus at 0.
- R4: A read transaction drives `{2'b11, addr[5:0]}` until `ulpi_nxt` is sampled high. One turnaround cycle follows. The `ulpi_data_in` byte of the next cycle is stored in bits 15:8.
- R5: Bits 15:8 cannot be written by software, and a write transaction leaves them unchanged.
- R6: If `ulpi_dir` rises while the command byte or the write data byte is waiting for acceptance, the transaction is dropped. When `ulpi_dir` falls again, the transaction restarts from its command byte.
- R7: The link never drives the data bus while `ulpi_dir` is high or during the turnaround and capture cycles of a read.
- R8: A write to the word while bit 30 is 1 has no effect on any field, and the transaction in flight runs with its original address.
- R9: An idle write with bit 30 clear updates the direction, address and write-data fields and starts no bus activity.
- R10: If a transaction spends TMO_CYCLES cycles waiting for the PHY, bit 30 clears and bit 31 sets. A transaction whose acceptance comes sooner completes normally.
- R11: Bit 31 stays set until software starts a new transaction, and writing bit 31 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vp_wr_en | input | 1 | Write strobe for the viewport word |
| vp_wr_data | input | 32 | Word being written |
| vp_rd_data | output | 32 | Current viewport word |
| ulpi_dir | input | 1 | PHY owns the data bus when high |
| ulpi_nxt | input | 1 | PHY accepts or presents a byte |
| ulpi_data_in | input | 8 | Data bus value driven by the PHY |
| ulpi_data_out | output | 8 | Data bus value driven by the link |
| ulpi_data_oe | output | 1 | Link drives the data bus |
| ulpi_stp | output | 1 | Stop strobe ending a write |

## Verification
The bench sends writes and reads to all 64 immediate addresses, with varied acceptance delays and with random values in the upper address bits. A design that dropped the upper-bit masking would produce wrong command bytes. A design that counted the turnaround wrong would return stale read data. The bench raises `ulpi_dir` during the command phase and again during the data phase. A design that kept driving, or resumed mid-transfer without resending the command byte, would break the retry check. It writes the word while a transaction is running, so an unguarded register update would change the address in flight. It also runs the watchdog both to expiry and to just under the limit, so an off-by-one count, a timeout flag that is not sticky, or a flag that is never cleared all show up in the flag and run-bit checks.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;

  localparam int unsigned VP_WORD_W   = 32;
  localparam int unsigned ULPI_BYTE_W = 8;
  localparam int unsigned IMM_ADDR_W  = 6;

  localparam int unsigned VP_TMO_BIT  = 31;
  localparam int unsigned VP_RUN_BIT  = 30;
  localparam int unsigned VP_WR_BIT   = 29;
  localparam int unsigned VP_ADDR_LSB = 16;
  localparam int unsigned VP_RDAT_LSB = 8;
  localparam int unsigned VP_WDAT_LSB = 0;

  localparam logic [1:0] TXC_REG_WR = 2'b10;
  localparam logic [1:0] TXC_REG_RD = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_DATA,
    SQ_STOP,
    SQ_TURN,
    SQ_CAPT,
    SQ_HOLD
  } seq_state_t;

  // Command byte for an immediate register access
  function automatic logic [ULPI_BYTE_W-1:0] txcmd_byte(
      input logic is_wr, input logic [ULPI_BYTE_W-1:0] addr);
    logic [1:0] code;
    code = is_wr ? TXC_REG_WR : TXC_REG_RD;
    return {code, addr[IMM_ADDR_W-1:0]};
  endfunction

  function automatic logic [ULPI_BYTE_W-1:0] word_byte(
      input logic [VP_WORD_W-1:0] w, input int unsigned lsb);
    return w[lsb +: ULPI_BYTE_W];
  endfunction

  function automatic logic [VP_WORD_W-1:0] pack_word(
      input logic tmo, input logic run, input logic wr,
      input logic [ULPI_BYTE_W-1:0] addr,
      input logic [ULPI_BYTE_W-1:0] rdat,
      input logic [ULPI_BYTE_W-1:0] wdat);
    logic [VP_WORD_W-1:0] w;
    w = '0;
    w[VP_TMO_BIT] = tmo;
    w[VP_RUN_BIT] = run;
    w[VP_WR_BIT]  = wr;
    w[VP_ADDR_LSB +: ULPI_BYTE_W] = addr;
    w[VP_RDAT_LSB +: ULPI_BYTE_W] = rdat;
    w[VP_WDAT_LSB +: ULPI_BYTE_W] = wdat;
    return w;
  endfunction

endpackage

// File: rtl/ulpi_vp_cmdreg.sv
module ulpi_vp_cmdreg
  import ulpi_vp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [VP_WORD_W-1:0]   wr_word,
  input  logic                   seq_done,
  input  logic                   rd_valid,
  input  logic [ULPI_BYTE_W-1:0] rd_byte,
  input  logic                   tmo_evt,
  output logic                   run_q,
  output logic                   is_wr_q,
  output logic [ULPI_BYTE_W-1:0] addr_q,
  output logic [ULPI_BYTE_W-1:0] wdat_q,
  output logic [ULPI_BYTE_W-1:0] rdat_q,
  output logic                   tmo_q,
  output logic                   start_evt,
  output logic [VP_WORD_W-1:0]   word_out
);

  logic accept;
  logic unused_wr_bits;

  assign accept    = wr_en && !run_q;
  assign start_evt = accept && wr_word[VP_RUN_BIT];
  assign unused_wr_bits = ^{wr_word[VP_TMO_BIT], wr_word[28:24],
                            wr_word[VP_RDAT_LSB +: ULPI_BYTE_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      if (accept) begin
        run_q   <= wr_word[VP_RUN_BIT];
        is_wr_q <= wr_word[VP_WR_BIT];
        addr_q  <= word_byte(wr_word, VP_ADDR_LSB);
        wdat_q  <= word_byte(wr_word, VP_WDAT_LSB);
        if (wr_word[VP_RUN_BIT]) tmo_q <= 1'b0;
      end else if (seq_done || tmo_evt) begin
        run_q <= 1'b0;
      end
      if (tmo_evt)  tmo_q  <= 1'b1;
      if (rd_valid) rdat_q <= rd_byte;
    end
  end

  assign word_out = pack_word(tmo_q, run_q, is_wr_q, addr_q, rdat_q, wdat_q);

endmodule

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   is_wr,
  input  logic [ULPI_BYTE_W-1:0] addr,
  input  logic [ULPI_BYTE_W-1:0] wdat,
  input  logic                   tmo_evt,
  input  logic                   ulpi_dir,
  input  logic                   ulpi_nxt,
  input  logic [ULPI_BYTE_W-1:0] ulpi_din,
  output logic [ULPI_BYTE_W-1:0] ulpi_dout,
  output logic                   ulpi_oe,
  output logic                   ulpi_stp,
  output logic                   done_evt,
  output logic                   cap_evt,
  output logic [ULPI_BYTE_W-1:0] cap_byte,
  output logic                   abort_evt,
  output logic                   cmd_phase,
  output logic                   waiting,
  output logic                   idle
);

  seq_state_t st, nxt_st;
  logic       drive;

  always_comb begin
    nxt_st = st;
    unique case (st)
      SQ_IDLE: if (run) nxt_st = SQ_CMD;
      SQ_CMD: begin
        if (ulpi_dir)      nxt_st = SQ_HOLD;
        else if (ulpi_nxt) nxt_st = is_wr ? SQ_DATA : SQ_TURN;
      end
      SQ_DATA: begin
        if (ulpi_dir)      nxt_st = SQ_HOLD;
        else if (ulpi_nxt) nxt_st = SQ_STOP;
      end
      SQ_STOP: nxt_st = SQ_IDLE;
      SQ_TURN: nxt_st = SQ_CAPT;
      SQ_CAPT: nxt_st = SQ_IDLE;
      SQ_HOLD: if (!ulpi_dir) nxt_st = SQ_CMD;
      default: nxt_st = SQ_IDLE;
    endcase
    if (tmo_evt) nxt_st = SQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= nxt_st;
  end

  assign drive     = (st == SQ_CMD) || (st == SQ_DATA) || (st == SQ_STOP);
  assign ulpi_oe   = drive && !ulpi_dir;
  assign ulpi_stp  = (st == SQ_STOP);
  assign cmd_phase = (st == SQ_CMD);
  assign idle      = (st == SQ_IDLE);
  assign waiting   = (st == SQ_CMD) || (st == SQ_DATA) || (st == SQ_HOLD);
  assign abort_evt = ((st == SQ_CMD) || (st == SQ_DATA)) && ulpi_dir;
  assign done_evt  = (st == SQ_STOP) || (st == SQ_CAPT);
  assign cap_evt   = (st == SQ_CAPT);
  assign cap_byte  = ulpi_din;

  always_comb begin
    unique case (st)
      SQ_CMD:  ulpi_dout = txcmd_byte(is_wr, addr);
      SQ_DATA: ulpi_dout = wdat;
      default: ulpi_dout = '0;
    endcase
  end

endmodule

// File: rtl/ulpi_vp_wdog.sv
module ulpi_vp_wdog #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic idle,
  output logic tmo_evt
);

  localparam int unsigned     CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (idle)                   cnt <= '0;
    else if (waiting && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign tmo_evt = waiting && (cnt == LAST);

endmodule

// File: rtl/ulpi_regport.sv
module ulpi_regport
  import ulpi_vp_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vp_wr_en,
  input  logic [VP_WORD_W-1:0]   vp_wr_data,
  output logic [VP_WORD_W-1:0]   vp_rd_data,
  input  logic                   ulpi_dir,
  input  logic                   ulpi_nxt,
  input  logic [ULPI_BYTE_W-1:0] ulpi_data_in,
  output logic [ULPI_BYTE_W-1:0] ulpi_data_out,
  output logic                   ulpi_data_oe,
  output logic                   ulpi_stp
);

  logic                   run_q, is_wr_q, tmo_q, start_evt;
  logic [ULPI_BYTE_W-1:0] addr_q, wdat_q, rdat_q, cap_byte;
  logic                   done_evt, cap_evt, abort_evt, cmd_phase;
  logic                   waiting, idle, tmo_evt;

  ulpi_vp_cmdreg u_cmdreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (vp_wr_en),
    .wr_word   (vp_wr_data),
    .seq_done  (done_evt),
    .rd_valid  (cap_evt),
    .rd_byte   (cap_byte),
    .tmo_evt   (tmo_evt),
    .run_q     (run_q),
    .is_wr_q   (is_wr_q),
    .addr_q    (addr_q),
    .wdat_q    (wdat_q),
    .rdat_q    (rdat_q),
    .tmo_q     (tmo_q),
    .start_evt (start_evt),
    .word_out  (vp_rd_data)
  );

  ulpi_vp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .is_wr     (is_wr_q),
    .addr      (addr_q),
    .wdat      (wdat_q),
    .tmo_evt   (tmo_evt),
    .ulpi_dir  (ulpi_dir),
    .ulpi_nxt  (ulpi_nxt),
    .ulpi_din  (ulpi_data_in),
    .ulpi_dout (ulpi_data_out),
    .ulpi_oe   (ulpi_data_oe),
    .ulpi_stp  (ulpi_stp),
    .done_evt  (done_evt),
    .cap_evt   (cap_evt),
    .cap_byte  (cap_byte),
    .abort_evt (abort_evt),
    .cmd_phase (cmd_phase),
    .waiting   (waiting),
    .idle      (idle)
  );

  ulpi_vp_wdog #(.LIMIT(TMO_CYCLES)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .idle    (idle),
    .tmo_evt (tmo_evt)
  );

endmodule

// File: rtl/ulpi_regport_chk.sv
module ulpi_regport_chk
  import ulpi_vp_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vp_wr_en,
  input logic                   run_q,
  input logic                   is_wr_q,
  input logic [ULPI_BYTE_W-1:0] addr_q,
  input logic [ULPI_BYTE_W-1:0] wdat_q,
  input logic [ULPI_BYTE_W-1:0] rdat_q,
  input logic                   tmo_q,
  input logic                   start_evt,
  input logic                   done_evt,
  input logic                   tmo_evt,
  input logic                   cap_evt,
  input logic                   abort_evt,
  input logic                   cmd_phase,
  input logic [ULPI_BYTE_W-1:0] ulpi_data_in,
  input logic [ULPI_BYTE_W-1:0] ulpi_data_out,
  input logic                   ulpi_data_oe,
  input logic                   ulpi_stp
);

  AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);  // R3
  AST_CMD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_phase && ulpi_data_oe) |-> (ulpi_data_out[7:6] == {1'b1, !is_wr_q}));  // R4
  AST_RUN_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done_evt && !tmo_evt) |=> run_q);  // R2
  AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !run_q);  // R2
  AST_CAPT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (rdat_q == $past(ulpi_data_in)));  // R4
  AST_CAPT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> !ulpi_data_oe);  // R7
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!ulpi_data_oe && run_q));  // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_wr_en && run_q) |=> ($stable(addr_q) && $stable(wdat_q) && $stable(is_wr_q)));  // R8
  AST_TMO_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (!run_q && tmo_q));  // R10
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !start_evt) |=> tmo_q);  // R11
  AST_START_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!tmo_q && run_q));  // R11

endmodule

bind ulpi_regport ulpi_regport_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vp_wr_en      (vp_wr_en),
  .run_q         (run_q),
  .is_wr_q       (is_wr_q),
  .addr_q        (addr_q),
  .wdat_q        (wdat_q),
  .rdat_q        (rdat_q),
  .tmo_q         (tmo_q),
  .start_evt     (start_evt),
  .done_evt      (done_evt),
  .tmo_evt       (tmo_evt),
  .cap_evt       (cap_evt),
  .abort_evt     (abort_evt),
  .cmd_phase     (cmd_phase),
  .ulpi_data_in  (ulpi_data_in),
  .ulpi_data_out (ulpi_data_out),
  .ulpi_data_oe  (ulpi_data_oe),
  .ulpi_stp      (ulpi_stp)
);

// File: tb/ulpi_regport_tb_top.sv
`timescale 1ns/1ps
module ulpi_regport_tb_top;

  localparam int unsigned TMO = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vp_wr_en = 1'b0;
  logic [31:0] vp_wr_data = '0;
  logic [31:0] vp_rd_data;
  logic        ulpi_dir = 1'b0;
  logic        ulpi_nxt = 1'b0;
  logic [7:0]  ulpi_data_in = '0;
  logic [7:0]  ulpi_data_out;
  logic        ulpi_data_oe;
  logic        ulpi_stp;

  int tests = 0;
  int fails = 0;
  bit reported = 0;
  logic [7:0] phy_mem [64];
  logic [7:0] last_rd;

  always #2.5 clk = ~clk;

  ulpi_regport #(.TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .vp_wr_en(vp_wr_en), .vp_wr_data(vp_wr_data),
    .vp_rd_data(vp_rd_data), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
  );

  function automatic logic [31:0] mk(bit tmo, bit run, bit wr, logic [7:0] a,
                                     logic [7:0] junk, logic [7:0] d);
    return (32'(tmo) << 31) | (32'(run) << 30) | (32'(wr) << 29) |
           (32'(a) << 16) | (32'(junk) << 8) | 32'(d);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic vp_write(input logic [31:0] w);
    vp_wr_en = 1'b1;
    vp_wr_data = w;
    tick();
    vp_wr_en = 1'b0;
    vp_wr_data = '0;
  endtask

  task automatic wait_tx(input logic [7:0] exp, input string req);
    int n = 0;
    while (!(ulpi_data_oe && ulpi_data_out == exp) && n < 20) begin
      tick();
      n++;
    end
    chk(req, {23'd0, ulpi_data_oe, ulpi_data_out}, {23'd0, 1'b1, exp});
  endtask

  // Command byte already visible; PHY accepts after dly cycles
  task automatic write_finish(input logic [7:0] a, input logic [7:0] d, input int dly);
    repeat (dly) tick();
    chk("R3 command byte held", {24'd0, ulpi_data_out}, {24'd0, 8'h80 | (a & 8'h3F)});
    ulpi_nxt = 1'b1;
    tick();
    chk("R3 data byte", {23'd0, ulpi_data_oe, ulpi_data_out}, {23'd0, 1'b1, d});
    tick();
    chk("R3 stop cycle", {23'd0, ulpi_stp, ulpi_data_out}, {23'd0, 1'b1, 8'h00});
    ulpi_nxt = 1'b0;
    phy_mem[a[5:0]] = d;
    tick();
    chk("R3 stop single", {31'd0, ulpi_stp}, 32'd0);
    chk("R2 run cleared after write", {31'd0, vp_rd_data[30]}, 32'd0);
    chk("R5 readback kept by write", {24'd0, vp_rd_data[15:8]}, {24'd0, last_rd});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int dly);
    vp_write(mk(0, 1, 1, a, 8'hA5, d));
    chk("R2 run set", {31'd0, vp_rd_data[30]}, 32'd1);
    wait_tx(8'h80 | (a & 8'h3F), "R3 write command byte");
    write_finish(a, d, dly);
  endtask

  task automatic read_finish(input logic [7:0] a, input int dly);
    logic [7:0] exp;
    exp = phy_mem[a[5:0]];
    wait_tx(8'hC0 | (a & 8'h3F), "R4 read command byte");
    repeat (dly) tick();
    ulpi_nxt = 1'b1;
    tick();
    ulpi_nxt = 1'b0;
    ulpi_dir = 1'b1;
    chk("R7 no drive in turnaround", {31'd0, ulpi_data_oe}, 32'd0);
    tick();
    ulpi_data_in = exp;
    chk("R7 no drive in capture", {31'd0, ulpi_data_oe}, 32'd0);
    tick();
    ulpi_dir = 1'b0;
    ulpi_data_in = 8'h00;
    chk("R4 read byte", {24'd0, vp_rd_data[15:8]}, {24'd0, exp});
    chk("R2 run cleared after read", {31'd0, vp_rd_data[30]}, 32'd0);
    last_rd = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int n;
    last_rd = 8'h00;
    for (int i = 0; i < 64; i++) phy_mem[i] = 8'h00;
    repeat (3) tick();
    chk("R1 word in reset", vp_rd_data, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 word after reset", vp_rd_data, 32'd0);
    chk("R1 bus idle", {30'd0, ulpi_data_oe, ulpi_stp}, 32'd0);

    // Address sweep, upper address bits varied (R3, R4, R5)
    for (int a = 0; a < 64; a++)
      do_write(8'(a | ((a % 4) << 6)), 8'((a * 37 + 5) % 256), a % 3);
    for (int a = 0; a < 64; a++) begin
      vp_write(mk(0, 1, 0, 8'(a | (((a + 1) % 4) << 6)), 8'h5A, 8'h3C));
      chk("R2 read word layout", vp_rd_data & 32'h7FFF_00FF,
          mk(0, 1, 0, 8'(a | (((a + 1) % 4) << 6)), 8'h00, 8'h3C));
      read_finish(8'(a | (((a + 1) % 4) << 6)), a % 4);
    end
    do_write(8'h11, 8'hE7, 1);

    // R9: idle field update without start
    vp_write(mk(1, 0, 1, 8'h2B, 8'hFF, 8'h9D));
    chk("R9 fields updated", vp_rd_data, mk(0, 0, 1, 8'h2B, last_rd, 8'h9D));
    n = 0;
    repeat (10) begin tick(); if (ulpi_data_oe || ulpi_stp) n++; end
    chk("R9 no bus activity", n, 0);

    // R8: write while busy is ignored
    vp_write(mk(0, 1, 0, 8'h07, 8'h00, 8'h00));
    tick();
    vp_write(mk(0, 1, 1, 8'h30, 8'h00, 8'h55));
    chk("R8 fields unchanged", vp_rd_data & 32'h3FFF_00FF, mk(0, 0, 0, 8'h07, 8'h00, 8'h00));
    read_finish(8'h07, 2);
    chk("R8 original address read", {24'd0, vp_rd_data[23:16]}, 32'h07);

    // R6/R7: abort in command phase
    vp_write(mk(0, 1, 1, 8'h15, 8'h00, 8'h6E));
    wait_tx(8'h95, "R3 command before abort");
    ulpi_dir = 1'b1;
    tick();
    chk("R7 released under dir", {31'd0, ulpi_data_oe}, 32'd0);
    tick();
    chk("R7 still released", {31'd0, ulpi_data_oe}, 32'd0);
    ulpi_dir = 1'b0;
    wait_tx(8'h95, "R6 command resent");
    write_finish(8'h15, 8'h6E, 0);

    // R6: abort in data phase resends command byte
    vp_write(mk(0, 1, 1, 8'h22, 8'h00, 8'hB4));
    wait_tx(8'hA2, "R3 command before data abort");
    ulpi_nxt = 1'b1;
    tick();
    ulpi_nxt = 1'b0;
    ulpi_dir = 1'b1;
    tick();
    chk("R7 released in data abort", {31'd0, ulpi_data_oe}, 32'd0);
    ulpi_dir = 1'b0;
    tick();
    chk("R6 restart at command byte", {23'd0, ulpi_data_oe, ulpi_data_out}, {23'd0, 1'b1, 8'hA2});
    write_finish(8'h22, 8'hB4, 1);
    vp_write(mk(0, 1, 0, 8'h22, 8'h00, 8'h00));
    read_finish(8'h22, 0);

    // R10: watchdog expiry
    vp_write(mk(0, 1, 1, 8'h09, 8'h00, 8'h01));
    n = 0;
    while (vp_rd_data[30] && n < int'(TMO) + 20) begin n++; tick(); end
    chk("R10 run cycles before timeout", n, int'(TMO) + 1);
    chk("R10 timeout flag set", {31'd0, vp_rd_data[31]}, 32'd1);
    chk("R10 bus released", {31'd0, ulpi_data_oe}, 32'd0);
    repeat (5) tick();
    vp_write(mk(0, 0, 0, 8'h09, 8'h00, 8'h01));
    chk("R11 flag sticky across idle write", {31'd0, vp_rd_data[31]}, 32'd1);
    vp_write(mk(0, 1, 0, 8'h22, 8'h00, 8'h00));
    chk("R11 flag cleared by start", {31'd0, vp_rd_data[31]}, 32'd0);
    read_finish(8'h22, 1);

    // R10: acceptance just inside the limit
    do_write(8'h3E, 8'hC3, int'(TMO) - 6);
    chk("R10 no timeout when in time", {31'd0, vp_rd_data[31]}, 32'd0);

    report();
  end

endmodule